// File: doc/BRIEF.md
# Buffer-Aware Mesh Route Computation

This block chooses the output port for the head flit of a packet at one router of a two-dimensional mesh. It takes the router's own column and row, the packet's destination column and row, and four flags. Each flag reports whether the bypass buffer of a powered-down neighbour (north, south, east, west) can take another flit.

Normally the route is dimension-ordered: the column is resolved first, then the row. When either horizontal neighbour reports a full bypass buffer, the packet may move vertically first, provided the vertical neighbour it needs has room. This lets traffic go around a congested east-west path while the vertical offset is still non-zero.

The decision is registered. A single head-flit strobe produces one cycle of `port_valid` carrying a one-hot port vector.

The control is a two-state machine:
- `ST_IDLE` means no decision is on the output.
- `ST_ISSUE` means a decision is being presented.

Its transitions are:
- `T_ACCEPT` (IDLE to ISSUE on a strobe)
- `T_RETIRE` (ISSUE to IDLE without a strobe)
- `T_CHAIN` (ISSUE to ISSUE on a back-to-back strobe)
- `T_REST` (IDLE to IDLE without a strobe)

Top module: `mesh_route_unit`

## Requirements
- R1: After reset, and before any head-flit strobe, `port_valid` is 0 and `port_sel` is all zero.
- R2: `port_valid` is 1 in exactly the cycle after a cycle in which `hd_valid` was 1, and is 0 otherwise. Strobes may arrive in every cycle.
- R3: The `port_sel` bit order is bit4 Local, bit3 North, bit2 South, bit1 East, bit0 West. While `port_valid` is 1, exactly one bit is set. While `port_valid` is 0, `port_sel` is all zero.
- R4: The `nbr_free` bit order is bit3 North, bit2 South, bit1 East, bit0 West. If `nbr_free[1]` or `nbr_free[0]` is 0, and `nbr_free[3]` is 1, and `here_y < dest_y`, the port is North. This holds whatever the column relation is.
- R5: If R4 does not apply, and `nbr_free[1]` or `nbr_free[0]` is 0, and `nbr_free[2]` is 1, and `here_y > dest_y`, the port is South. This holds whatever the column relation is.
- R6: If neither R4 nor R5 applies, the port is East when `here_x < dest_x` and West when `here_x > dest_x`.
- R7: If neither R4 nor R5 applies and the columns match, the port is North when `here_y < dest_y`, South when `here_y > dest_y`, and Local when both coordinates are equal.
- R8: The vertical-first override is tested before the column comparison. It is not taken when both horizontal flags are 1, nor when the needed vertical flag is 0; in those cases R6 and R7 decide.
- R9: Coordinate and flag inputs presented while `hd_valid` is 0 have no effect on `port_valid` or `port_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| hd_valid | input | 1 | Head flit present this cycle |
| here_x | input | 3 | Local router column |
| here_y | input | 3 | Local router row |
| dest_x | input | 3 | Destination column |
| dest_y | input | 3 | Destination row |
| nbr_free | input | 4 | Neighbour bypass buffer has room: {N,S,E,W} |
| port_valid | output | 1 | Decision present |
| port_sel | output | 5 | One-hot port: {Local,North,South,East,West} |

## Verification
The hardest case to reach is the fallback from an override: one horizontal flag is low and a vertical offset exists, but the vertical neighbour that offset needs is full. Here the route must revert to plain column-first order.

The stimulus reaches this case by sweeping every combination of the four coordinates and all sixteen flag patterns. Each flag pattern therefore meets every coordinate relation.

Strobes are issued back to back, which exercises the chained transition on every cycle. Idle stretches with moving inputs exercise the rest transition and show that unstrobed inputs are ignored.

// File: rtl/mesh_route_pkg.sv
package mesh_route_pkg;

    localparam int PORT_COUNT = 5;

    // One-hot bit positions of the port vector
    localparam int P_LOCAL = 4;
    localparam int P_NORTH = 3;
    localparam int P_SOUTH = 2;
    localparam int P_EAST  = 1;
    localparam int P_WEST  = 0;

    // Bit positions of the neighbour availability flags
    localparam int F_NORTH = 3;
    localparam int F_SOUTH = 2;
    localparam int F_EAST  = 1;
    localparam int F_WEST  = 0;

    typedef logic [PORT_COUNT-1:0] port_vec_t;

    localparam port_vec_t PV_NONE  = '0;
    localparam port_vec_t PV_LOCAL = port_vec_t'(1) << P_LOCAL;
    localparam port_vec_t PV_NORTH = port_vec_t'(1) << P_NORTH;
    localparam port_vec_t PV_SOUTH = port_vec_t'(1) << P_SOUTH;
    localparam port_vec_t PV_EAST  = port_vec_t'(1) << P_EAST;
    localparam port_vec_t PV_WEST  = port_vec_t'(1) << P_WEST;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ISSUE = 1'b1
    } route_state_t;

    // Relation of a local coordinate to a destination coordinate
    typedef enum logic [1:0] {
        REL_EQ   = 2'd0,
        REL_LESS = 2'd1,
        REL_MORE = 2'd2
    } coord_rel_t;

endpackage

// File: rtl/route_coord_cmp.sv
module route_coord_cmp
    import mesh_route_pkg::*;
#(
    parameter int W = 3
) (
    input  logic [W-1:0] here_c,
    input  logic [W-1:0] dest_c,
    output coord_rel_t   rel
);

    always_comb begin
        if (here_c < dest_c) begin
            rel = REL_LESS;
        end else if (here_c > dest_c) begin
            rel = REL_MORE;
        end else begin
            rel = REL_EQ;
        end
    end

endmodule

// File: rtl/route_yx_override.sv
module route_yx_override
    import mesh_route_pkg::*;
#(
    parameter int FLAG_W = 4
) (
    input  logic [FLAG_W-1:0] free_flags,
    input  coord_rel_t        rel_y,
    output logic              go_north,
    output logic              go_south
);

    logic horiz_blocked;

    // A horizontal neighbour without room is the trigger for the override
    assign horiz_blocked = !free_flags[F_EAST] || !free_flags[F_WEST];

    always_comb begin
        go_north = 1'b0;
        go_south = 1'b0;
        // North is evaluated first; South only when North is not chosen
        if (horiz_blocked && free_flags[F_NORTH] && (rel_y == REL_LESS)) begin
            go_north = 1'b1;
        end else if (horiz_blocked && free_flags[F_SOUTH] && (rel_y == REL_MORE)) begin
            go_south = 1'b1;
        end
    end

endmodule

// File: rtl/route_xy_pick.sv
module route_xy_pick
    import mesh_route_pkg::*;
(
    input  coord_rel_t rel_x,
    input  coord_rel_t rel_y,
    input  logic       go_north,
    input  logic       go_south,
    output port_vec_t  pick
);

    always_comb begin
        if (go_north) begin
            pick = PV_NORTH;
        end else if (go_south) begin
            pick = PV_SOUTH;
        end else begin
            unique case (rel_x)
                REL_LESS: pick = PV_EAST;
                REL_MORE: pick = PV_WEST;
                default: begin
                    unique case (rel_y)
                        REL_LESS: pick = PV_NORTH;
                        REL_MORE: pick = PV_SOUTH;
                        default:  pick = PV_LOCAL;
                    endcase
                end
            endcase
        end
    end

endmodule

// File: rtl/route_port_fsm.sv
module route_port_fsm
    import mesh_route_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      strobe,
    input  port_vec_t pick,
    output logic      out_valid,
    output port_vec_t out_sel
);

    route_state_t state_q, state_d;
    port_vec_t    sel_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = strobe ? ST_ISSUE : ST_IDLE;   // T_ACCEPT / T_REST
            ST_ISSUE: state_d = strobe ? ST_ISSUE : ST_IDLE;   // T_CHAIN / T_RETIRE
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= PV_NONE;
        end else if (state_d == ST_ISSUE) begin
            sel_q <= pick;
        end else begin
            sel_q <= PV_NONE;
        end
    end

    assign out_valid = (state_q == ST_ISSUE);
    assign out_sel   = sel_q;

endmodule

// File: rtl/mesh_route_unit.sv
module mesh_route_unit
    import mesh_route_pkg::*;
#(
    parameter int MESH_X = 8,
    parameter int MESH_Y = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      hd_valid,
    input  logic [$clog2(MESH_X)-1:0] here_x,
    input  logic [$clog2(MESH_Y)-1:0] here_y,
    input  logic [$clog2(MESH_X)-1:0] dest_x,
    input  logic [$clog2(MESH_Y)-1:0] dest_y,
    input  logic [3:0]                nbr_free,
    output logic                      port_valid,
    output logic [4:0]                port_sel
);

    localparam int XW = $clog2(MESH_X);
    localparam int YW = $clog2(MESH_Y);

    coord_rel_t rel_x, rel_y;
    logic       go_north, go_south;
    port_vec_t  pick;

    route_coord_cmp #(.W(XW)) u_cmp_x (
        .here_c (here_x),
        .dest_c (dest_x),
        .rel    (rel_x)
    );

    route_coord_cmp #(.W(YW)) u_cmp_y (
        .here_c (here_y),
        .dest_c (dest_y),
        .rel    (rel_y)
    );

    route_yx_override #(.FLAG_W(4)) u_ovr (
        .free_flags (nbr_free),
        .rel_y      (rel_y),
        .go_north   (go_north),
        .go_south   (go_south)
    );

    route_xy_pick u_pick (
        .rel_x    (rel_x),
        .rel_y    (rel_y),
        .go_north (go_north),
        .go_south (go_south),
        .pick     (pick)
    );

    route_port_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe    (hd_valid),
        .pick      (pick),
        .out_valid (port_valid),
        .out_sel   (port_sel)
    );

endmodule

// File: rtl/mesh_route_unit_chk.sv
module mesh_route_unit_chk #(
    parameter int XW = 3,
    parameter int YW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          hd_valid,
    input logic [XW-1:0] here_x,
    input logic [YW-1:0] here_y,
    input logic [XW-1:0] dest_x,
    input logic [YW-1:0] dest_y,
    input logic [3:0]    nbr_free,
    input logic          port_valid,
    input logic [4:0]    port_sel
);

    // R2
    strobe_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hd_valid |=> port_valid);

    // R2
    quiet_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hd_valid |=> !port_valid);

    // R3
    one_hot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        port_valid |-> ($countones(port_sel) == 1));

    // R3
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !port_valid |-> (port_sel == 5'b0));

    // R4
    north_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hd_valid && (!nbr_free[1] || !nbr_free[0]) && nbr_free[3] && (here_y < dest_y))
        |=> (port_sel == 5'b01000));

    // R7
    local_arrive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hd_valid && (here_x == dest_x) && (here_y == dest_y)) |=> (port_sel == 5'b10000));

    // R6
    east_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hd_valid && (&nbr_free[1:0]) && (here_x < dest_x)) |=> (port_sel == 5'b00010));

endmodule

bind mesh_route_unit mesh_route_unit_chk #(.XW(XW), .YW(YW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hd_valid   (hd_valid),
    .here_x     (here_x),
    .here_y     (here_y),
    .dest_x     (dest_x),
    .dest_y     (dest_y),
    .nbr_free   (nbr_free),
    .port_valid (port_valid),
    .port_sel   (port_sel)
);

// File: tb/mesh_route_unit_tb.sv
`timescale 1ns/1ps
module mesh_route_unit_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hd_valid = 1'b0;
    logic [2:0] here_x = '0, here_y = '0, dest_x = '0, dest_y = '0;
    logic [3:0] nbr_free = '0;
    logic       port_valid;
    logic [4:0] port_sel;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    mesh_route_unit u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .hd_valid   (hd_valid),
        .here_x     (here_x),
        .here_y     (here_y),
        .dest_x     (dest_x),
        .dest_y     (dest_y),
        .nbr_free   (nbr_free),
        .port_valid (port_valid),
        .port_sel   (port_sel)
    );

    // Expected port from the requirement text
    function automatic logic [4:0] exp_port(input logic [15:0] v);
        logic [2:0] hx, hy, dx, dy;
        logic [3:0] f;
        logic blk;
        hx = v[2:0]; hy = v[5:3]; dx = v[8:6]; dy = v[11:9]; f = v[15:12];
        blk = !f[1] || !f[0];
        if (blk && f[3] && hy < dy)      return 5'b01000;
        else if (blk && f[2] && hy > dy) return 5'b00100;
        else if (hx < dx)                return 5'b00010;
        else if (hx > dx)                return 5'b00001;
        else if (hy < dy)                return 5'b01000;
        else if (hy > dy)                return 5'b00100;
        else                             return 5'b10000;
    endfunction

    function automatic string req_of(input logic [15:0] v);
        logic blk;
        blk = !v[13] || !v[12];
        if (blk && v[15] && v[5:3] < v[11:9]) return "R4";
        if (blk && v[14] && v[5:3] > v[11:9]) return "R5";
        if (blk && v[5:3] != v[11:9])         return "R8";
        if (v[2:0] != v[8:6])                 return "R6";
        return "R7";
    endfunction

    task automatic check(input bit ok, input string req, input logic [5:0] act, input logic [5:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic drive(input logic [15:0] v, input logic s);
        hd_valid = s;
        here_x = v[2:0]; here_y = v[5:3]; dest_x = v[8:6]; dest_y = v[11:9]; nbr_free = v[15:12];
    endtask

    initial begin
        logic [15:0] prev;
        logic [4:0]  e;
        #1;
        // R1: reset state
        check(port_valid == 1'b0 && port_sel == 5'b0, "R1", {port_valid, port_sel}, 6'b0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(port_valid == 1'b0 && port_sel == 5'b0, "R1", {port_valid, port_sel}, 6'b0);

        // R9: unstrobed inputs change nothing
        for (int k = 0; k < 40; k++) begin
            drive(16'(k * 7919), 1'b0);
            @(negedge clk);
            check(port_valid == 1'b0 && port_sel == 5'b0, "R9", {port_valid, port_sel}, 6'b0);
        end

        // Exhaustive sweep, back-to-back strobes (R2, R3, R4..R8)
        prev = '0;
        for (int v = 0; v < 65536; v++) begin
            drive(16'(v), 1'b1);
            @(negedge clk);
            e = exp_port(16'(v));
            check(port_valid == 1'b1 && port_sel == e, req_of(16'(v)), {port_valid, port_sel}, {1'b1, e});
            prev = 16'(v);
        end

        // R2: valid drops after the last strobe; R3: selection cleared
        drive(~prev, 1'b0);
        @(negedge clk);
        check(port_valid == 1'b0 && port_sel == 5'b0, "R2", {port_valid, port_sel}, 6'b0);

        // R2: isolated strobes with gaps
        for (int k = 0; k < 64; k++) begin
            drive(16'(k * 1031 + 5), 1'b1);
            @(negedge clk);
            e = exp_port(16'(k * 1031 + 5));
            check(port_valid == 1'b1 && port_sel == e, "R2", {port_valid, port_sel}, {1'b1, e});
            drive(16'(k * 977), 1'b0);
            @(negedge clk);
            check(port_valid == 1'b0 && port_sel == 5'b0, "R9", {port_valid, port_sel}, 6'b0);
        end

        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule